// File: doc/BRIEF.md
# Latency-Driven Issue Interlock

This unit sits at the point where decoded instructions leave a single-issue, in-order pipeline. It holds back an instruction until enough cycles have passed since an earlier instruction wrote one of its operands. For each register it keeps the class of the most recent in-flight writer and a countdown of cycles that still matter. A fixed table gives the number of intervening cycles needed between a producer and a consumer, and that number depends on both classes. A double load feeds a double store at once. A floating-point result must wait longer before a later floating-point operation can use it.

Upstream presents one decoded instruction per cycle with a valid strobe. The instruction is its class, two source register numbers and one destination register number. It holds that instruction unchanged while `stall` is high. The unit grants `issue` in the cycle the instruction may proceed. Because issue is in order, a held instruction blocks everything behind it. A free-running counter records how many cycles an instruction was held, for performance statistics.

Top module: `issue_interlock`

## Requirements
- R1: After reset no register is pending and `stall_count` is 0, so the first valid instruction issues in the cycle it is presented.
- R2: Class codes on `in_class` are 0 none, 1 integer ALU, 2 floating-point ALU, 3 double load, 4 double store, 5 branch, and only codes 1, 2 and 3 write their destination. While `in_valid` is high exactly one of `issue` and `stall` is high, and both are low otherwise. A held instruction issues only once its hazard clears.
- R3: A floating-point ALU result read by a floating-point ALU operation needs 3 intervening cycles, so back-to-back placement gives 3 stall cycles.
- R4: A floating-point ALU result read by a double store, through either source, needs 2 intervening cycles.
- R5: A double load result read by a floating-point ALU operation needs 1 intervening cycle.
- R6: A double load result read by a double store needs no intervening cycle and causes no stall.
- R7: An integer ALU result read by a branch needs 1 intervening cycle. Every producer/consumer pair not named in R3 to R7 needs none.
- R8: Cycles spent issuing unrelated instructions count toward the required gap. A consumer may issue in the cycle numbered producer-issue + gap + 1, and not before.
- R9: Source register 0, a source with no pending writer, and a destination written by a non-writing class or equal to 0 never cause a stall.
- R10: When both sources are pending, the instruction is held until the larger of the two remaining waits has passed, and the remaining wait drops by one each held cycle.
- R11: A newer write to a register replaces the older pending entry, so a later reader waits according to the newest producer only.
- R12: `stall_count` increases by exactly one in every cycle in which `stall` is high and holds otherwise.
- R13: The sequence load, floating-point add using the load, store of the sum, integer pointer decrement, branch on the pointer takes 9 cycles from the first issue to the branch issue inclusive, 4 of them stall cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A decoded instruction is presented |
| in_class | input | 3 | Instruction class code (see R2) |
| in_src_a | input | RID_W (5) | First source register number |
| in_src_b | input | RID_W (5) | Second source register number (store data) |
| in_dst | input | RID_W (5) | Destination register number |
| issue | output | 1 | Presented instruction issues this cycle |
| stall | output | 1 | Presented instruction is held this cycle |
| stall_count | output | CNT_W (16) | Number of held cycles since reset |

## Verification
Each table pair is tried back to back, with the distance counted from the producer's issue cycle to the consumer's. This separates a gap that is too short from one that is too long, and it catches a pair that is missing from the table. Unrelated instructions placed between producer and consumer show whether elapsed cycles are credited. Two pending sources with different waits, and a register rewritten by a faster producer, tell a largest-wait merge apart from a first-match one and a newest-writer entry apart from a stale one. Register 0, non-writing classes and unmatched sources confirm that these create no entry. The five-instruction loop body checks the whole timing against its known total.

// File: rtl/il_pkg.sv
package il_pkg;

  typedef enum logic [2:0] {
    CL_NONE  = 3'd0,
    CL_INT   = 3'd1,
    CL_FPALU = 3'd2,
    CL_LDD   = 3'd3,
    CL_STD   = 3'd4,
    CL_BR    = 3'd5
  } iclass_t;

  localparam int MAX_LAT = 3;
  localparam int LAT_W   = $clog2(MAX_LAT + 1);

  // Required intervening cycles between producer and consumer classes.
  function automatic logic [LAT_W-1:0] pair_lat(input logic [2:0] prod,
                                                input logic [2:0] cons);
    logic [LAT_W-1:0] r;
    r = '0;
    if (prod == CL_FPALU && cons == CL_FPALU) r = LAT_W'(3);
    else if (prod == CL_FPALU && cons == CL_STD) r = LAT_W'(2);
    else if (prod == CL_LDD && cons == CL_FPALU) r = LAT_W'(1);
    else if (prod == CL_INT && cons == CL_BR) r = LAT_W'(1);
    return r;
  endfunction

  // Longest gap any consumer can need from this producer.
  function automatic logic [LAT_W-1:0] hold_len(input logic [2:0] prod);
    logic [LAT_W-1:0] m;
    m = '0;
    for (int c = 0; c < 8; c++) begin
      if (pair_lat(prod, 3'(c)) > m) m = pair_lat(prod, 3'(c));
    end
    return m;
  endfunction

  function automatic logic writes_dst(input logic [2:0] c);
    return (c == CL_INT) || (c == CL_FPALU) || (c == CL_LDD);
  endfunction

  // Cycles still to wait given the producer entry and consumer class.
  function automatic logic [LAT_W-1:0] wait_need(input logic [2:0] prod,
                                                 input logic [LAT_W-1:0] rem,
                                                 input logic [2:0] cons);
    logic [LAT_W-1:0] lat;
    logic [LAT_W-1:0] elapsed;
    lat     = pair_lat(prod, cons);
    elapsed = hold_len(prod) - rem;
    if (rem != '0 && lat > elapsed) return lat - elapsed;
    return '0;
  endfunction

endpackage

// File: rtl/il_scoreboard.sv
module il_scoreboard
  import il_pkg::*;
#(
  parameter int NREGS = 32,
  localparam int RID_W = $clog2(NREGS)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [RID_W-1:0]                 wr_id,
  input  logic [2:0]                       wr_cls,
  output logic [NREGS-1:0][2:0]            cls_q,
  output logic [NREGS-1:0][LAT_W-1:0]      rem_q
);

  for (genvar r = 0; r < NREGS; r++) begin : g_ent
    if (r == 0) begin : g_zero
      assign cls_q[r] = 3'd0;
      assign rem_q[r] = '0;
    end else begin : g_live
      logic [2:0]       ent_cls;
      logic [LAT_W-1:0] ent_rem;
      logic             hit;
      assign hit = wr_en && (wr_id == RID_W'(r));
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          ent_cls <= 3'd0;
          ent_rem <= '0;
        end else if (hit) begin
          ent_cls <= wr_cls;
          ent_rem <= hold_len(wr_cls);
        end else if (ent_rem != '0) begin
          ent_rem <= ent_rem - 1'b1;
        end
      end
      assign cls_q[r] = ent_cls;
      assign rem_q[r] = ent_rem;
    end
  end

endmodule

// File: rtl/il_hazard.sv
module il_hazard
  import il_pkg::*;
#(
  parameter int NREGS = 32,
  parameter int NSRC  = 2,
  localparam int RID_W = $clog2(NREGS)
) (
  input  logic [NREGS-1:0][2:0]       cls_q,
  input  logic [NREGS-1:0][LAT_W-1:0] rem_q,
  input  logic [2:0]                  cons_cls,
  input  logic [NSRC-1:0][RID_W-1:0]  srcs,
  output logic [LAT_W-1:0]            need_max
);

  logic [NSRC-1:0][LAT_W-1:0] need;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    always_comb begin
      if (srcs[s] == '0) need[s] = '0;
      else need[s] = wait_need(cls_q[srcs[s]], rem_q[srcs[s]], cons_cls);
    end
  end

  always_comb begin
    need_max = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (need[s] > need_max) need_max = need[s];
    end
  end

endmodule

// File: rtl/il_stall_counter.sv
module il_stall_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else if (inc) count <= count + 1'b1;
  end

endmodule

// File: rtl/issue_interlock.sv
module issue_interlock
  import il_pkg::*;
#(
  parameter int NREGS = 32,
  parameter int CNT_W = 16,
  localparam int RID_W = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [2:0]       in_class,
  input  logic [RID_W-1:0] in_src_a,
  input  logic [RID_W-1:0] in_src_b,
  input  logic [RID_W-1:0] in_dst,
  output logic             issue,
  output logic             stall,
  output logic [CNT_W-1:0] stall_count
);

  logic [NREGS-1:0][2:0]       cls_q;
  logic [NREGS-1:0][LAT_W-1:0] rem_q;
  logic [LAT_W-1:0]            need_max;
  logic                        hazard;
  logic                        wr_en;

  assign hazard = (need_max != '0);
  assign stall  = in_valid && hazard;
  assign issue  = in_valid && !hazard;
  assign wr_en  = issue && writes_dst(in_class) && (in_dst != '0);

  il_scoreboard #(.NREGS(NREGS)) u_sb (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_id  (in_dst),
    .wr_cls (in_class),
    .cls_q  (cls_q),
    .rem_q  (rem_q)
  );

  il_hazard #(.NREGS(NREGS), .NSRC(2)) u_hz (
    .cls_q    (cls_q),
    .rem_q    (rem_q),
    .cons_cls (in_class),
    .srcs     ({in_src_b, in_src_a}),
    .need_max (need_max)
  );

  il_stall_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (stall),
    .count (stall_count)
  );

endmodule

// File: rtl/issue_interlock_chk.sv
module issue_interlock_chk
  import il_pkg::*;
#(
  parameter int NREGS = 32,
  parameter int CNT_W = 16,
  localparam int RID_W = $clog2(NREGS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [2:0]       in_class,
  input logic [RID_W-1:0] in_src_a,
  input logic [RID_W-1:0] in_src_b,
  input logic [RID_W-1:0] in_dst,
  input logic             issue,
  input logic             stall,
  input logic [CNT_W-1:0] stall_count,
  input logic [LAT_W-1:0] need_max,
  input logic             wr_en
);

  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else past_ok <= 1'b1;
  end

  a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (issue != stall));

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> (!issue && !stall && !wr_en));

  a_r3_fp_fp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && in_class == CL_FPALU && in_dst != '0) |=>
      (!(in_valid && in_class == CL_FPALU && in_src_a == $past(in_dst)) || stall));

  a_r4_fp_store_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && in_class == CL_FPALU && in_dst != '0) |=>
      (!(in_valid && in_class == CL_STD && in_src_b == $past(in_dst)) || stall));

  a_r5_load_fp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && in_class == CL_LDD && in_dst != '0) |=>
      (!(in_valid && in_class == CL_FPALU && in_src_a == $past(in_dst)) || stall));

  a_r6_load_store_free: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && in_class == CL_LDD && in_dst != '0) |=>
      (!(in_valid && in_class == CL_STD && in_src_a == '0 &&
         in_src_b == $past(in_dst)) || issue));

  a_r7_int_branch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && in_class == CL_INT && in_dst != '0) |=>
      (!(in_valid && in_class == CL_BR && in_src_a == $past(in_dst)) || stall));

  a_r9_reg0_free: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_src_a == '0 && in_src_b == '0) |-> issue);

  a_r10_wait_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (!(in_valid && $stable(in_class) && $stable(in_src_a) &&
                 $stable(in_src_b)) || need_max == $past(need_max) - 1'b1));

  a_r12_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |=> (stall_count == $past(stall_count) + CNT_W'($past(stall))));

endmodule

bind issue_interlock issue_interlock_chk #(.NREGS(NREGS), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/issue_interlock_test.sv
module issue_interlock_test;

  localparam int NREGS = 32;
  localparam int CNT_W = 16;
  localparam int RW    = $clog2(NREGS);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [2:0]    in_class = 3'd0;
  logic [RW-1:0] in_src_a = '0;
  logic [RW-1:0] in_src_b = '0;
  logic [RW-1:0] in_dst = '0;
  logic          issue;
  logic          stall;
  logic [CNT_W-1:0] stall_count;

  always #5 clk = ~clk;

  issue_interlock #(.NREGS(NREGS), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
    .in_src_a(in_src_a), .in_src_b(in_src_b), .in_dst(in_dst),
    .issue(issue), .stall(stall), .stall_count(stall_count)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int exp_cnt = 0;
  int dut_issue = 0;
  int wr_cyc [NREGS];
  int wr_cls [NREGS];
  bit wr_ok  [NREGS];

  // Gap table restated from the requirements.
  function automatic int gap(input int p, input int c);
    if (p == 2) return (c == 2) ? 3 : (c == 4) ? 2 : 0;
    if (p == 3) return (c == 2) ? 1 : 0;
    if (p == 1) return (c == 5) ? 1 : 0;
    return 0;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  task automatic idle(input int n, input string req);
    in_valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(!issue && !stall, req, "idle issue/stall", {issue, stall}, 0);
      check(int'(stall_count) == exp_cnt, req, "stall_count", int'(stall_count), exp_cnt);
      @(posedge clk); #1; cyc++;
    end
  endtask

  task automatic exec(input int cls, input int a, input int b, input int d,
                      input string req);
    bit go;
    in_valid = 1'b1; in_class = 3'(cls);
    in_src_a = RW'(a); in_src_b = RW'(b); in_dst = RW'(d);
    go = 1'b0;
    for (int k = 0; k < 10 && !go; k++) begin
      @(negedge clk);
      go = 1'b1;
      if (a != 0 && wr_ok[a] && cyc < wr_cyc[a] + gap(wr_cls[a], cls) + 1) go = 1'b0;
      if (b != 0 && wr_ok[b] && cyc < wr_cyc[b] + gap(wr_cls[b], cls) + 1) go = 1'b0;
      if (issue) dut_issue = cyc;
      check(issue == go && stall == !go, req, "issue vs model", issue, go);
      if (go) begin
        if ((cls == 1 || cls == 2 || cls == 3) && d != 0) begin
          wr_ok[d] = 1'b1; wr_cyc[d] = cyc; wr_cls[d] = cls;
        end
      end else begin
        exp_cnt++;
      end
      check(int'(stall_count) == exp_cnt - (go ? 0 : 1), req, "stall_count",
            int'(stall_count), exp_cnt - (go ? 0 : 1));
      @(posedge clk); #1; cyc++;
    end
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R2 watchdog expired: actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int t0;
    int c0;
    for (int r = 0; r < NREGS; r++) begin wr_ok[r] = 0; wr_cyc[r] = 0; wr_cls[r] = 0; end
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    check(int'(stall_count) == 0 && !issue && !stall, "R1", "reset state",
          int'(stall_count), 0);
    rst_n = 1'b1;
    @(posedge clk); #1; cyc = 1;

    // R1: first instruction issues at once
    exec(2, 18, 17, 20, "R1");
    check(dut_issue == cyc - 1, "R1", "first issue cycle", dut_issue, cyc - 1);
    idle(5, "R2");

    // R3: fp -> fp back to back
    exec(2, 18, 0, 20, "R3"); t0 = dut_issue;
    exec(2, 20, 18, 22, "R3");
    check(dut_issue - t0 == 4, "R3", "fp->fp distance", dut_issue - t0, 4);
    idle(5, "R3");

    // R4: fp -> store data and store address
    exec(2, 18, 0, 20, "R4"); t0 = dut_issue;
    exec(4, 0, 20, 0, "R4");
    check(dut_issue - t0 == 3, "R4", "fp->store data", dut_issue - t0, 3);
    idle(5, "R4");
    exec(2, 18, 0, 21, "R4"); t0 = dut_issue;
    exec(4, 21, 0, 0, "R4");
    check(dut_issue - t0 == 3, "R4", "fp->store addr", dut_issue - t0, 3);
    idle(5, "R4");

    // R5 and R6: load consumers
    exec(3, 1, 0, 16, "R5"); t0 = dut_issue;
    exec(2, 16, 0, 20, "R5");
    check(dut_issue - t0 == 2, "R5", "load->fp", dut_issue - t0, 2);
    idle(5, "R5");
    exec(3, 1, 0, 16, "R6"); t0 = dut_issue;
    exec(4, 0, 16, 0, "R6");
    check(dut_issue - t0 == 1, "R6", "load->store", dut_issue - t0, 1);
    idle(5, "R6");

    // R7: int -> branch, and zero-gap pairs
    exec(1, 1, 0, 3, "R7"); t0 = dut_issue;
    exec(5, 3, 0, 0, "R7");
    check(dut_issue - t0 == 2, "R7", "int->branch", dut_issue - t0, 2);
    idle(5, "R7");
    exec(1, 1, 0, 3, "R7"); t0 = dut_issue;
    exec(1, 3, 0, 4, "R7");
    check(dut_issue - t0 == 1, "R7", "int->int", dut_issue - t0, 1);
    idle(5, "R7");
    exec(2, 18, 0, 20, "R7"); t0 = dut_issue;
    exec(5, 20, 0, 0, "R7");
    check(dut_issue - t0 == 1, "R7", "fp->branch", dut_issue - t0, 1);
    idle(5, "R7");

    // R8: an unrelated instruction in between is credited
    exec(2, 18, 0, 20, "R8"); t0 = dut_issue;
    exec(1, 5, 0, 6, "R8");
    exec(2, 20, 0, 22, "R8");
    check(dut_issue - t0 == 4, "R8", "fp->x->fp", dut_issue - t0, 4);
    idle(5, "R8");

    // R9: register 0, non-writing class, unmatched source
    exec(2, 18, 0, 0, "R9");
    exec(2, 0, 0, 22, "R9"); t0 = dut_issue;
    check(dut_issue == cyc - 1, "R9", "reg0 no hazard", dut_issue, cyc - 1);
    idle(5, "R9");
    exec(4, 0, 18, 7, "R9"); t0 = dut_issue;
    exec(2, 7, 0, 22, "R9");
    check(dut_issue - t0 == 1, "R9", "store dst ignored", dut_issue - t0, 1);
    exec(2, 9, 10, 23, "R9");
    check(dut_issue == cyc - 1, "R9", "unmatched src", dut_issue, cyc - 1);
    idle(5, "R9");

    // R10: two pending sources, larger wait governs (both orders)
    exec(2, 18, 0, 20, "R10"); t0 = dut_issue;
    exec(3, 1, 0, 21, "R10");
    exec(2, 21, 20, 22, "R10");
    check(dut_issue - t0 == 4, "R10", "max of waits a/b", dut_issue - t0, 4);
    idle(5, "R10");
    exec(2, 18, 0, 20, "R10"); t0 = dut_issue;
    exec(3, 1, 0, 21, "R10");
    exec(2, 20, 21, 22, "R10");
    check(dut_issue - t0 == 4, "R10", "max of waits b/a", dut_issue - t0, 4);
    idle(5, "R10");

    // R11: newer faster producer replaces the entry
    exec(2, 18, 0, 20, "R11"); t0 = dut_issue;
    exec(3, 1, 0, 20, "R11");
    exec(2, 20, 0, 22, "R11");
    check(dut_issue - t0 == 3, "R11", "newest writer", dut_issue - t0, 3);
    idle(5, "R11");

    // R13: loop body with R12 count delta
    c0 = int'(stall_count);
    exec(3, 1, 0, 16, "R13"); t0 = dut_issue;
    exec(2, 16, 18, 20, "R13");
    exec(4, 1, 20, 0, "R13");
    exec(1, 1, 0, 1, "R13");
    exec(5, 1, 0, 0, "R13");
    check(dut_issue - t0 + 1 == 9, "R13", "loop cycles", dut_issue - t0 + 1, 9);
    check(int'(stall_count) - c0 == 4, "R12", "loop stall cycles",
          int'(stall_count) - c0, 4);
    idle(3, "R12");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule